// File: doc/BRIEF.md
# Multi-Line Stereo Serial Audio Transmitter

This block turns a single stream of 32-bit audio samples into serial data on up to `LINES` parallel I2S data lines. Each line carries one stereo pair. Software writes samples to one data port. The samples are interleaved: left then right for line 0, then left and right for line 1, and so on for each active line. The block stores them in a FIFO. An external clock generator supplies a one-cycle strobe for each transmit edge of the bit clock, plus the frame clock level. On each strobe the block shifts one bit out on every active line.

A control word holds three fields: a run switch, a data switch and the number of active lines. Each line has its own small control word. It sets whether the line is enabled and whether its slot uses I2S timing (MSB one bit clock late) or left-justified timing (MSB on the frame edge). At the start of each left slot, the block moves the samples gathered during the previous frame into the line shifters. It then pulls the next frame's samples from the FIFO. If the FIFO runs dry, zeros go out in place of the missing samples and a sticky flag is raised. Clearing the run switch stops the datapath and flushes the FIFO. The line settings and the control fields survive the stop.

Top module: `i2so_tx`

## Requirements
- R1: After reset every `sdata` line is 0 and `underrun` is 0.
- R2: Register map, byte addresses on `wr_addr`. 0x000 is the sample data port. 0x004 is the control word: bit 0 = run, bit 24 = data enable, bits 23:13 = active line count minus one. A count above `LINES` is treated as `LINES`. Line `i` has its control word at P*0x20 + i*0x20, where P is the smallest power of two not below `LINES` (0x080, 0x0A0, 0x0C0, 0x0E0 for four lines). In that word, bit 0 enables the line and bit 1 selects I2S timing (clear = left-justified).
- R3: A line drives 0 unless run, data enable and its own enable are all set and its index is below the active count.
- R4: Within a frame, samples are taken from the FIFO in the order line 0 left, line 0 right, line 1 left, and so on, for every line below the active count. A line that is disabled still consumes its two samples.
- R5: In left-justified timing, the MSB of a word appears at the transmit edge where the frame clock changes. The left word goes out while the frame clock is low and the right word while it is high, MSB first.
- R6: In I2S timing, each word starts one transmit edge later than in R5. Its LSB is driven at the first edge of the following slot.
- R7: Samples fetched at the start of a frame's left slot go out in the following frame. The first frame after starting carries zeros.
- R8: When the FIFO is empty at a fetch, that slot carries all zeros and `underrun` becomes 1. It stays 1 until run is cleared.
- R9: Clearing run flushes the FIFO, clears `underrun` and idles the shifters. The line control words and the control fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte address |
| wr_data | input | 32 | Register write data |
| bclk_tx | input | 1 | One-cycle strobe per bit clock transmit edge |
| frame_clk | input | 1 | Frame clock level (low = left slot) |
| sdata | output | LINES | Serial data, one bit per line |
| underrun | output | 1 | Sticky FIFO-empty flag |

## Verification
The bench decodes each line's bit stream by its own edge count for both timing modes. A shifter off by one edge, or one that loses the I2S LSB across the slot boundary, shows up as a halved or shifted word. Mixed configurations check fetch order: disabled lines inside the active count and idle lines above it. A design that skips a disabled line's samples hands every later line the wrong pair. A one-sample run and a flushed-FIFO run check that missing data becomes zeros with the flag raised. With data enable clear, a design that leaks samples or fetches anyway produces nonzero bits, or later words that do not match.

// File: rtl/i2so_pkg.sv
package i2so_pkg;
  localparam int SAMPLE_W     = 32;
  localparam int REG_DATA     = 0;
  localparam int REG_CTL      = 4;
  localparam int LINE_STRIDE  = 32;
  localparam int CTL_RUN_BIT  = 0;
  localparam int CTL_DEN_BIT  = 24;
  localparam int CTL_CNT_LSB  = 13;
  localparam int CTL_CNT_W    = 11;
  localparam int LINE_EN_BIT  = 0;
  localparam int LINE_I2S_BIT = 1;

  function automatic int pow2_at_least(input int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction
endpackage

// File: rtl/i2so_regs.sv
module i2so_regs
  import i2so_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 12,
  localparam int CNT_W = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              fifo_wr,
  output logic              run_en,
  output logic              data_en,
  output logic [CNT_W-1:0]  act_cnt,
  output logic [LINES-1:0]  line_en,
  output logic [LINES-1:0]  line_i2s
);
  localparam int LBASE = pow2_at_least(LINES) * LINE_STRIDE;

  logic                 run_q, run_n, den_q, den_n;
  logic [CTL_CNT_W-1:0] fld_q, fld_n;
  logic [LINES-1:0]     en_q, en_n, i2s_q, i2s_n;
  logic                 ctl_hit;
  logic                 unused_bits;

  assign ctl_hit     = wr_en && (wr_addr == ADDR_W'(REG_CTL));
  assign fifo_wr     = wr_en && (wr_addr == ADDR_W'(REG_DATA));
  assign unused_bits = ^{wr_data[31:25], wr_data[12:2]};

  always_comb begin
    run_n = run_q;
    den_n = den_q;
    fld_n = fld_q;
    en_n  = en_q;
    i2s_n = i2s_q;
    if (ctl_hit) begin
      run_n = wr_data[CTL_RUN_BIT];
      den_n = wr_data[CTL_DEN_BIT];
      fld_n = wr_data[CTL_CNT_LSB +: CTL_CNT_W];
    end
    for (int i = 0; i < LINES; i++) begin
      if (wr_en && (wr_addr == ADDR_W'(LBASE + LINE_STRIDE * i))) begin
        en_n[i]  = wr_data[LINE_EN_BIT];
        i2s_n[i] = wr_data[LINE_I2S_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      den_q <= 1'b0;
      fld_q <= '0;
      en_q  <= '0;
      i2s_q <= '0;
    end else begin
      run_q <= run_n;
      den_q <= den_n;
      fld_q <= fld_n;
      en_q  <= en_n;
      i2s_q <= i2s_n;
    end
  end

  always_comb begin
    if (fld_q >= CTL_CNT_W'(LINES)) act_cnt = CNT_W'(LINES);
    else                            act_cnt = CNT_W'(fld_q) + CNT_W'(1);
  end

  assign run_en   = run_q;
  assign data_en  = den_q;
  assign line_en  = en_q;
  assign line_i2s = i2s_q;
endmodule

// File: rtl/i2so_fifo.sv
module i2so_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]   mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [PTR_W:0]   lvl_q, lvl_n;
  logic             do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == (PTR_W+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    lvl_n = lvl_q;
    if (clr) begin
      wp_n  = '0;
      rp_n  = '0;
      lvl_n = '0;
    end else begin
      if (do_push) wp_n = (wp_q == PTR_W'(DEPTH-1)) ? '0 : wp_q + PTR_W'(1);
      if (do_pop)  rp_n = (rp_q == PTR_W'(DEPTH-1)) ? '0 : rp_q + PTR_W'(1);
      lvl_n = lvl_q + (PTR_W+1)'(do_push) - (PTR_W+1)'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      lvl_q <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp_q] <= din;
  end
endmodule

// File: rtl/i2so_fetch.sv
module i2so_fetch #(
  parameter int LINES = 4,
  parameter int W     = 32,
  localparam int CNT_W = $clog2(LINES + 1),
  localparam int IDX_W = CNT_W + 1,
  localparam int SLOTS = 2 * LINES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_en,
  input  logic                    active,
  input  logic                    frame_go,
  input  logic [CNT_W-1:0]        act_cnt,
  input  logic [W-1:0]            fifo_dout,
  input  logic                    fifo_empty,
  output logic                    fifo_pop,
  output logic [SLOTS-1:0][W-1:0] nxt,
  output logic                    underrun
);
  logic                    busy_q, busy_n;
  logic [IDX_W-1:0]        idx_q, idx_n;
  logic [SLOTS-1:0][W-1:0] nxt_q, nxt_n;
  logic                    ur_q, ur_n;
  logic                    want;

  assign want     = busy_q && (idx_q < {act_cnt, 1'b0});
  assign fifo_pop = want && !fifo_empty;

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    nxt_n  = nxt_q;
    ur_n   = ur_q;
    if (!run_en) begin
      busy_n = 1'b0;
      idx_n  = '0;
      nxt_n  = '0;
      ur_n   = 1'b0;
    end else if (frame_go && active) begin
      busy_n = 1'b1;
      idx_n  = '0;
    end else if (busy_q) begin
      nxt_n[idx_q] = fifo_pop ? fifo_dout : '0;
      if (want && fifo_empty) ur_n = 1'b1;
      idx_n = idx_q + IDX_W'(1);
      if (idx_q == IDX_W'(SLOTS-1)) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      nxt_q  <= '0;
      ur_q   <= 1'b0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
      nxt_q  <= nxt_n;
      ur_q   <= ur_n;
    end
  end

  assign nxt      = nxt_q;
  assign underrun = ur_q;
endmodule

// File: rtl/i2so_lane.sv
module i2so_lane #(
  parameter int W = 32,
  localparam int KW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  input  logic          side,
  input  logic [KW-1:0] kpos,
  input  logic          swap,
  input  logic [W-1:0]  nxt_l,
  input  logic [W-1:0]  nxt_r,
  input  logic          on,
  input  logic          i2s,
  output logic          sdata
);
  logic [W-1:0] l_q, l_n, r_q, r_n;
  logic         sd_q, sd_n;
  logic [W-1:0] src_l, src_r, word;
  logic         bit_v;

  assign src_l = swap ? nxt_l : l_q;
  assign src_r = swap ? nxt_r : r_q;
  assign word  = side ? src_r : src_l;

  always_comb begin
    if (i2s) begin
      if (kpos == '0) bit_v = side ? l_q[0] : r_q[0];
      else            bit_v = word[W - int'(kpos)];
    end else begin
      bit_v = word[W - 1 - int'(kpos)];
    end
  end

  always_comb begin
    l_n  = l_q;
    r_n  = r_q;
    sd_n = sd_q;
    if (!active) begin
      l_n  = '0;
      r_n  = '0;
      sd_n = 1'b0;
    end else if (tick) begin
      if (swap) begin
        l_n = nxt_l;
        r_n = nxt_r;
      end
      sd_n = on & bit_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q  <= '0;
      r_q  <= '0;
      sd_q <= 1'b0;
    end else begin
      l_q  <= l_n;
      r_q  <= r_n;
      sd_q <= sd_n;
    end
  end

  assign sdata = sd_q;
endmodule

// File: rtl/i2so_tx.sv
module i2so_tx
  import i2so_pkg::*;
#(
  parameter int LINES      = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              bclk_tx,
  input  logic              frame_clk,
  output logic [LINES-1:0]  sdata,
  output logic              underrun
);
  localparam int W     = SAMPLE_W;
  localparam int KW    = $clog2(W);
  localparam int CNT_W = $clog2(LINES + 1);
  localparam int SLOTS = 2 * LINES;

  logic                    fifo_wr, run_en, data_en, active;
  logic [CNT_W-1:0]        act_cnt;
  logic [LINES-1:0]        line_en, line_i2s, lane_on;
  logic                    fifo_pop, fifo_empty, fifo_full, fifo_clr;
  logic [W-1:0]            fifo_dout;
  logic [SLOTS-1:0][W-1:0] nxt;
  logic                    run_prev_q;
  logic                    lr_q, lr_n;
  logic [KW-1:0]           k_q, k_n;
  logic                    tick, edge_chg, swap;

  i2so_regs #(.LINES(LINES), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_wr(fifo_wr), .run_en(run_en), .data_en(data_en), .act_cnt(act_cnt),
    .line_en(line_en), .line_i2s(line_i2s)
  );

  assign active   = run_en && data_en;
  assign fifo_clr = run_prev_q && !run_en;

  i2so_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(fifo_wr), .din(wr_data),
    .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full)
  );

  assign tick     = bclk_tx && active;
  assign edge_chg = (frame_clk != lr_q);
  assign swap     = tick && edge_chg && !frame_clk;

  always_comb begin
    lr_n = lr_q;
    k_n  = k_q;
    if (!active) begin
      lr_n = 1'b1;
      k_n  = '0;
    end else if (tick) begin
      lr_n = frame_clk;
      if (edge_chg)                k_n = '0;
      else if (k_q != KW'(W - 1)) k_n = k_q + KW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q       <= 1'b1;
      k_q        <= '0;
      run_prev_q <= 1'b0;
    end else begin
      lr_q       <= lr_n;
      k_q        <= k_n;
      run_prev_q <= run_en;
    end
  end

  i2so_fetch #(.LINES(LINES), .W(W)) i_fetch (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .active(active), .frame_go(swap),
    .act_cnt(act_cnt), .fifo_dout(fifo_dout), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .nxt(nxt), .underrun(underrun)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_lane
    assign lane_on[i] = line_en[i] && (CNT_W'(i) < act_cnt);
    i2so_lane #(.W(W)) i_lane (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tick), .side(frame_clk),
      .kpos(edge_chg ? '0 : k_n), .swap(swap), .nxt_l(nxt[2*i]), .nxt_r(nxt[2*i+1]),
      .on(lane_on[i]), .i2s(line_i2s[i]), .sdata(sdata[i])
    );
  end

  logic unused_full;
  assign unused_full = fifo_full;
endmodule

// File: rtl/i2so_tx_chk.sv
module i2so_tx_chk #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             data_en,
  input logic             tick,
  input logic [LINES-1:0] lane_on,
  input logic [LINES-1:0] sdata,
  input logic             underrun,
  input logic             fifo_pop,
  input logic             fifo_empty,
  input logic             run_prev_q
);
  a_r3_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_en && data_en) |=> (sdata == '0));

  a_r3_off_lane_silent: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((sdata & ~$past(lane_on)) == '0));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && run_en) |=> underrun);

  a_r8_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !underrun);

  a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  a_r9_flush_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (run_prev_q && !run_en) |=> fifo_empty);
endmodule

bind i2so_tx i2so_tx_chk #(.LINES(LINES)) i_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .data_en(data_en), .tick(tick),
  .lane_on(lane_on), .sdata(sdata), .underrun(underrun), .fifo_pop(fifo_pop),
  .fifo_empty(fifo_empty), .run_prev_q(run_prev_q)
);

// File: tb/test_i2so_tx.sv
module test_i2so_tx;
  localparam int LINES = 4;
  localparam int NE    = 129;

  typedef struct packed {
    logic [2:0] cnt;
    logic [3:0] i2s;
    logic [3:0] en;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{3'd1, 4'b0001, 4'b1111, 8'h11},
    '{3'd2, 4'b0000, 4'b1111, 8'h3C},
    '{3'd4, 4'b0101, 4'b1111, 8'hC7},
    '{3'd4, 4'b1111, 4'b1011, 8'h82},
    '{3'd3, 4'b0010, 4'b1111, 8'h6E}
  };

  logic             clk;
  logic             rst_n, wr_en, bclk_tx, frame_clk;
  logic [11:0]      wr_addr;
  logic [31:0]      wr_data;
  logic [LINES-1:0] sdata;
  logic             underrun;
  int               n_tests, n_fail;
  bit               cap [LINES][NE];

  i2so_tx #(.LINES(LINES), .FIFO_DEPTH(16), .ADDR_W(12)) i_i2so_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bclk_tx(bclk_tx), .frame_clk(frame_clk), .sdata(sdata), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] samp(input logic [7:0] seed, input int idx);
    logic [7:0] b;
    b = 8'(idx);
    return {seed, b, ~seed, b ^ 8'h5A};
  endfunction

  function automatic logic [31:0] ctlw(input bit run, input bit den, input int cnt);
    return 32'(run) | (32'(den) << 24) | (32'(cnt - 1) << 13);
  endfunction

  function automatic logic [31:0] word_at(input int li, input int s);
    logic [31:0] w;
    w = '0;
    for (int b = 0; b < 32; b++) w = {w[30:0], cap[li][s + b]};
    return w;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_edges();
    for (int e = 0; e < NE; e++) begin
      @(negedge clk);
      frame_clk = ((e / 32) % 2) == 1;
      bclk_tx = 1'b1;
      @(negedge clk);
      for (int li = 0; li < LINES; li++) cap[li][e] = sdata[li];
      bclk_tx = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  function automatic int ones_in(input int li, input int s, input int n);
    int c;
    c = 0;
    for (int e = s; e < s + n; e++) c += int'(cap[li][e]);
    return c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    bclk_tx = 1'b0; frame_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset sdata", 32'(sdata), 32'h0);
    check("R1", "reset underrun", 32'(underrun), 32'h0);

    // Table walk: R2 R4 R5 R6 R7 R8
    for (int v = 0; v < 5; v++) begin
      wr(12'h004, 32'h0);
      for (int i = 0; i < LINES; i++)
        wr(12'h080 + 12'(32 * i), {30'b0, VECS[v].i2s[i], VECS[v].en[i]});
      for (int s = 0; s < 2 * int'(VECS[v].cnt); s++) wr(12'h000, samp(VECS[v].seed, s));
      wr(12'h004, ctlw(1, 1, int'(VECS[v].cnt)));
      run_edges();
      for (int li = 0; li < LINES; li++) begin
        int off;
        logic [31:0] el, er;
        bit live;
        off = VECS[v].i2s[li] ? 1 : 0;
        live = VECS[v].en[li] && (li < int'(VECS[v].cnt));
        el = live ? samp(VECS[v].seed, 2 * li) : 32'h0;
        er = live ? samp(VECS[v].seed, 2 * li + 1) : 32'h0;
        check("R7", $sformatf("v%0d line%0d first frame ones", v, li), 32'(ones_in(li, 0, 64)), 0);
        check(VECS[v].i2s[li] ? "R6" : "R5", $sformatf("v%0d line%0d left (R4 order)", v, li),
              word_at(li, 64 + off), el);
        check(VECS[v].i2s[li] ? "R6" : "R5", $sformatf("v%0d line%0d right (R3 gating)", v, li),
              word_at(li, 96 + off), er);
      end
      check("R8", $sformatf("v%0d underrun after drain", v), 32'(underrun), 32'h1);
      wr(12'h004, 32'h0);
      @(negedge clk);
      check("R8", $sformatf("v%0d underrun cleared by stop", v), 32'(underrun), 32'h0);
    end

    // R8: one sample only, second slot must be zeros
    wr(12'h080, 32'h1);
    wr(12'h000, 32'hA5C3_0F96);
    wr(12'h004, ctlw(1, 1, 1));
    run_edges();
    check("R8", "single sample left", word_at(0, 64), 32'hA5C3_0F96);
    check("R8", "missing right is zero", word_at(0, 96), 32'h0);
    check("R8", "underrun raised", 32'(underrun), 32'h1);
    wr(12'h004, 32'h0);

    // R3: data enable clear keeps all lines at zero
    wr(12'h004, ctlw(1, 0, 1));
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    run_edges();
    begin
      int tot;
      tot = 0;
      for (int li = 0; li < LINES; li++) tot += ones_in(li, 0, NE);
      check("R3", "ones with data enable clear", 32'(tot), 32'h0);
    end

    // R9: stop flushes the FIFO, line settings survive
    wr(12'h004, 32'h0);
    @(negedge clk);
    check("R9", "underrun after stop", 32'(underrun), 32'h0);
    wr(12'h004, ctlw(1, 1, 1));
    run_edges();
    check("R9", "flushed left is zero", word_at(0, 64), 32'h0);
    check("R9", "flushed right is zero", word_at(0, 96), 32'h0);
    check("R8", "underrun after flushed start", 32'(underrun), 32'h1);
    wr(12'h004, 32'h0);
    wr(12'h000, 32'h1234_5678);
    wr(12'h000, 32'h9ABC_DEF0);
    wr(12'h004, ctlw(1, 1, 1));
    run_edges();
    check("R9", "line setting kept, left", word_at(0, 64), 32'h1234_5678);
    check("R9", "line setting kept, right", word_at(0, 96), 32'h9ABC_DEF0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule